// File: doc/BRIEF.md
# Serial Receive Queue with Trigger Interrupt

This block is the receive side of a serial port controller. It holds received characters together with their line-error and break flags, and hands them to the host one at a time when the host reads the data register. It takes characters from two places. One is the external deserializer, which delivers normal characters and line-break events. The other is the internal loopback path, which is used while the port is looped back to itself.

A mode input selects how deep the buffer is. In queue mode it is a circular buffer of `DEPTH` entries, where `DEPTH` is a power of two. With queue mode off it is a single holding register. Any change of the mode input flushes the buffer and asks the transmit side to flush as well. When an entry is popped, its flag bits are copied into a sticky receive-status register. A receive interrupt request is raised when the fill level reaches a trigger level, which is fixed at 1 by default. It is dropped when a read leaves the buffer one below that level, or when the host clears it.

Top module: `uart_rx_fifo`

## Requirements
- R1: After a synchronous reset, level_o is 0, empty_o is 1, full_o is 0, rx_irq_o is 0, stat_o is 0, rd_valid_o is 0 and tx_flush_o is 0, and the buffer is in single-entry mode.
- R2: With queue mode on, up to DEPTH entries are kept and returned in arrival order. An entry is 12 bits: bits [7:0] hold the character, bit 8 framing error, bit 9 parity error, bit 10 break and bit 11 overrun. A pop sampled at a clock edge shows the head entry on rd_data_o with rd_valid_o high just after that edge.
- R3: With queue mode off, the buffer holds exactly one entry.
- R4: A push that arrives while the level equals the effective depth is dropped. The stored entries stay unchanged and full_o stays high.
- R5: level_o, full_o and empty_o give the level after the pops and pushes of the previous edge. A pop from a full buffer clears full_o.
- R6: A pop on an empty buffer pulses rd_valid_o, leaves level_o at 0 and leaves stat_o unchanged.
- R7: When a pop and a push occur in the same cycle, the pop is taken first, so a push into a full buffer succeeds when it comes with a pop.
- R8: rx_irq_o is set when a push makes the level equal to TRIGGER. It is cleared when a pop (including a pop on empty) leaves the level plus one equal to TRIGGER. irq_clr_i clears it, and in the same cycle it acts before the pop and the push.
- R9: A pop from a non-empty buffer loads bits [11:8] of the popped entry into stat_o. stat_clr_i zeroes stat_o. If both happen in the same cycle, the pop wins.
- R10: ext_break_i pushes the entry 0x400 (break bit set, character 0). If ext_push_i is high in the same cycle, only the break entry is pushed.
- R11: While loopback_i is high, external characters and breaks are ignored and lb_push_i entries are accepted. While loopback_i is low, lb_push_i is ignored.
- R12: In a cycle where fifo_mode_i differs from the current mode, the buffer is emptied, the new mode is taken, and pops and pushes are ignored. The clear inputs still act. rx_irq_o is otherwise kept, and tx_flush_o is high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode_i | input | 1 | 1 selects queue mode (DEPTH entries), 0 selects the single-entry holding register |
| loopback_i | input | 1 | Loopback enable |
| ext_push_i | input | 1 | External character valid |
| ext_char_i | input | 8 | External character |
| ext_flags_i | input | 4 | External flags: bit0 framing, bit1 parity, bit2 break, bit3 overrun |
| ext_break_i | input | 1 | External line-break event |
| lb_push_i | input | 1 | Loopback entry valid |
| lb_entry_i | input | 12 | Loopback entry in the stored format |
| pop_i | input | 1 | Host data-register read |
| irq_clr_i | input | 1 | Clear the receive interrupt |
| stat_clr_i | input | 1 | Clear the receive-status register |
| rd_data_o | output | 12 | Entry returned by the last pop |
| rd_valid_o | output | 1 | A pop was served at the previous edge |
| stat_o | output | 4 | Receive-status flags of the last popped entry |
| level_o | output | 5 | Current fill level |
| full_o | output | 1 | Level equals the effective depth |
| empty_o | output | 1 | Level is zero |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_flush_o | output | 1 | One-cycle request to flush the transmit queue |

## Verification
The assertions take for granted that fifo_mode_i only changes on purpose. They also take for granted that, in the cycles they inspect, no unrelated push, pop or clear happens alongside the event under test. Every property therefore names the quiet inputs in its antecedent rather than relying on them. TRIGGER is assumed to lie between 1 and DEPTH. The stimulus first steps through every fill level of both modes with one input active at a time. It then runs a long pseudo-random mix with rare mode and loopback changes, so that combined pop, push and clear cycles occur at full, empty and mid levels.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  localparam int CHAR_W  = 8;
  localparam int FLAG_W  = 4;
  localparam int ENTRY_W = CHAR_W + FLAG_W;

  // bit 11 overrun, 10 break, 9 parity, 8 framing, 7:0 character
  typedef struct packed {
    logic              overrun;
    logic              brk;
    logic              parity;
    logic              framing;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  localparam rx_entry_t BREAK_ENTRY = '{overrun: 1'b0, brk: 1'b1, parity: 1'b0,
                                        framing: 1'b0, ch: '0};
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  rx_entry_t         wr_data_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic              stat_load_i,
  input  logic              stat_clr_i,
  output rx_entry_t         rd_data_o,
  output logic              rd_valid_o,
  output logic [FLAG_W-1:0] stat_o
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] rd_q;
  logic [FLAG_W-1:0]  stat_q;
  logic               vld_q;

  // storage port: plain write, registered read, no reset (block RAM friendly)
  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rd_en_i;
      if (stat_load_i)     stat_q <= mem[rd_addr_i][ENTRY_W-1:CHAR_W];
      else if (stat_clr_i) stat_q <= '0;
    end
  end

  assign rd_data_o  = rx_entry_t'(rd_q);
  assign rd_valid_o = vld_q;
  assign stat_o     = stat_q;

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stat_load_i && !stat_clr_i) |=> $stable(stat_q)); // R9
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_clr_i && !stat_load_i) |=> (stat_q == '0)); // R9
endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode_i,
  input  logic          loopback_i,
  input  logic          ext_push_i,
  input  rx_entry_t     ext_entry_i,
  input  logic          ext_break_i,
  input  logic          lb_push_i,
  input  rx_entry_t     lb_entry_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output rx_entry_t     wr_entry_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          pop_any_o,
  output logic          pop_hit_o,
  output logic          push_ok_o,
  output logic [CW-1:0] cnt_mid_o,
  output logic [CW-1:0] cnt_next_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          tx_flush_o
);
  logic          mode_q;
  logic [AW-1:0] rd_q;
  logic [CW-1:0] cnt_q;
  logic          full_q, empty_q, flush_q;

  logic          toggle;
  logic [CW-1:0] eff_depth;
  logic [AW-1:0] mask;
  logic          src_valid;
  rx_entry_t     src_entry;
  logic          pop_any, pop_hit, push_ok;
  logic [CW-1:0] cnt_mid, cnt_n;
  logic [AW-1:0] rd_mid;

  always_comb begin
    toggle    = fifo_mode_i ^ mode_q;
    eff_depth = mode_q ? CW'(DEPTH) : CW'(1);
    mask      = mode_q ? AW'(DEPTH - 1) : '0;

    // source select: loopback owns the input while enabled, break beats a character
    if (loopback_i) begin
      src_valid = lb_push_i;
      src_entry = lb_entry_i;
    end else if (ext_break_i) begin
      src_valid = 1'b1;
      src_entry = BREAK_ENTRY;
    end else begin
      src_valid = ext_push_i;
      src_entry = ext_entry_i;
    end

    // pop is served before push inside one cycle
    pop_any = pop_i & ~toggle;
    pop_hit = pop_any & (cnt_q != '0);
    cnt_mid = cnt_q - CW'(pop_hit);
    rd_mid  = pop_hit ? ((rd_q + AW'(1)) & mask) : rd_q;
    push_ok = src_valid & ~toggle & (cnt_mid < eff_depth);
    cnt_n   = cnt_mid + CW'(push_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      rd_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      flush_q <= 1'b0;
    end else if (toggle) begin
      mode_q  <= fifo_mode_i;
      rd_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      flush_q <= 1'b1;
    end else begin
      rd_q    <= rd_mid;
      cnt_q   <= cnt_n;
      full_q  <= (cnt_n == eff_depth);
      empty_q <= (cnt_n == '0);
      flush_q <= 1'b0;
    end
  end

  assign wr_en_o    = push_ok;
  assign wr_addr_o  = (rd_mid + cnt_mid[AW-1:0]) & mask;
  assign wr_entry_o = src_entry;
  assign rd_addr_o  = rd_q;
  assign pop_any_o  = pop_any;
  assign pop_hit_o  = pop_hit;
  assign push_ok_o  = push_ok;
  assign cnt_mid_o  = cnt_mid;
  assign cnt_next_o = cnt_n;
  assign level_o    = cnt_q;
  assign full_o     = full_q;
  assign empty_o    = empty_q;
  assign tx_flush_o = flush_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= eff_depth); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == eff_depth && src_valid && !pop_i && !toggle) |=> ($stable(cnt_q) && full_q)); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q)); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && pop_i && !src_valid && !toggle) |=> (cnt_q == '0 && empty_q)); // R6
  AST_LB_OFF_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!loopback_i && lb_push_i && !ext_push_i && !ext_break_i && !pop_i && !toggle)
      |=> $stable(cnt_q)); // R11
  AST_LB_ON_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (loopback_i && (ext_push_i || ext_break_i) && !lb_push_i && !pop_i && !toggle)
      |=> $stable(cnt_q)); // R11
  AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    toggle |=> (cnt_q == '0 && empty_q && tx_flush_o)); // R12
endmodule

// File: rtl/rxq_irq.sv
`timescale 1ns/1ps
module rxq_irq #(
  parameter int CW   = 5,
  parameter int TRIG = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_clr_i,
  input  logic          pop_any_i,
  input  logic          push_ok_i,
  input  logic [CW-1:0] cnt_mid_i,
  input  logic [CW-1:0] cnt_next_i,
  output logic          irq_o
);
  logic irq_q, irq_n;

  // order inside a cycle: host clear, then pop, then push
  always_comb begin
    irq_n = irq_q;
    if (irq_clr_i) irq_n = 1'b0;
    if (pop_any_i && ((cnt_mid_i + CW'(1)) == CW'(TRIG))) irq_n = 1'b0;
    if (push_ok_i && (cnt_next_i == CW'(TRIG))) irq_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_n;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(push_ok_i)); // R8
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i && !push_ok_i) |=> !irq_q); // R8
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_mode_i,
  input  logic               loopback_i,
  input  logic               ext_push_i,
  input  logic [CHAR_W-1:0]  ext_char_i,
  input  logic [FLAG_W-1:0]  ext_flags_i,
  input  logic               ext_break_i,
  input  logic               lb_push_i,
  input  logic [ENTRY_W-1:0] lb_entry_i,
  input  logic               pop_i,
  input  logic               irq_clr_i,
  input  logic               stat_clr_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               rd_valid_o,
  output logic [FLAG_W-1:0]  stat_o,
  output logic [CW-1:0]      level_o,
  output logic               full_o,
  output logic               empty_o,
  output logic               rx_irq_o,
  output logic               tx_flush_o
);
  rx_entry_t     ext_entry, lb_entry, wr_entry, rd_entry;
  logic          wr_en, pop_any, pop_hit, push_ok;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] cnt_mid, cnt_next;

  assign ext_entry = rx_entry_t'({ext_flags_i, ext_char_i});
  assign lb_entry  = rx_entry_t'(lb_entry_i);

  rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .fifo_mode_i (fifo_mode_i),
    .loopback_i  (loopback_i),
    .ext_push_i  (ext_push_i),
    .ext_entry_i (ext_entry),
    .ext_break_i (ext_break_i),
    .lb_push_i   (lb_push_i),
    .lb_entry_i  (lb_entry),
    .pop_i       (pop_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_entry_o  (wr_entry),
    .rd_addr_o   (rd_addr),
    .pop_any_o   (pop_any),
    .pop_hit_o   (pop_hit),
    .push_ok_o   (push_ok),
    .cnt_mid_o   (cnt_mid),
    .cnt_next_o  (cnt_next),
    .level_o     (level_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .tx_flush_o  (tx_flush_o)
  );

  rxq_store #(.DEPTH(DEPTH)) i_store (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_entry),
    .rd_en_i     (pop_any),
    .rd_addr_i   (rd_addr),
    .stat_load_i (pop_hit),
    .stat_clr_i  (stat_clr_i),
    .rd_data_o   (rd_entry),
    .rd_valid_o  (rd_valid_o),
    .stat_o      (stat_o)
  );

  rxq_irq #(.CW(CW), .TRIG(TRIGGER)) i_irq (
    .clk        (clk),
    .rst        (rst),
    .irq_clr_i  (irq_clr_i),
    .pop_any_i  (pop_any),
    .push_ok_i  (push_ok),
    .cnt_mid_i  (cnt_mid),
    .cnt_next_i (cnt_next),
    .irq_o      (rx_irq_o)
  );

  assign rd_data_o = rd_entry;
endmodule

// File: tb/test_uart_rx_fifo.sv
`timescale 1ns/1ps
module test_uart_rx_fifo;
  localparam int DEPTH = 16;
  localparam int TRIG  = 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_mode = 1'b0, loopback = 1'b0;
  logic ext_push = 1'b0, ext_break = 1'b0, lb_push = 1'b0, pop = 1'b0;
  logic irq_clr = 1'b0, stat_clr = 1'b0;
  logic [7:0]  ext_char = '0;
  logic [3:0]  ext_flags = '0;
  logic [11:0] lb_entry = '0;
  logic [11:0] rd_data;
  logic        rd_valid, full, empty, rx_irq, tx_flush;
  logic [3:0]  stat;
  logic [CW-1:0] level;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int m_q[$];
  bit m_mode = 1'b0, m_irq = 1'b0;
  int m_stat = 0;

  always #2.5 clk = ~clk;

  uart_rx_fifo #(.DEPTH(DEPTH), .TRIGGER(TRIG)) i_uart_rx_fifo (
    .clk(clk), .rst(rst), .fifo_mode_i(fifo_mode), .loopback_i(loopback),
    .ext_push_i(ext_push), .ext_char_i(ext_char), .ext_flags_i(ext_flags),
    .ext_break_i(ext_break), .lb_push_i(lb_push), .lb_entry_i(lb_entry),
    .pop_i(pop), .irq_clr_i(irq_clr), .stat_clr_i(stat_clr),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .stat_o(stat), .level_o(level),
    .full_o(full), .empty_o(empty), .rx_irq_o(rx_irq), .tx_flush_o(tx_flush)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: drive, tick, advance the model from the requirements, compare
  task automatic cyc(input bit ep, input bit [7:0] ec, input bit [3:0] ef, input bit eb,
                     input bit lp, input bit [11:0] le, input bit po, input bit ic,
                     input bit sc, input string tag);
    bit tog, exp_vld, have_dat, sv;
    int exp_dat, depth, se;
    ext_push = ep; ext_char = ec; ext_flags = ef; ext_break = eb;
    lb_push = lp; lb_entry = le; pop = po; irq_clr = ic; stat_clr = sc;
    @(posedge clk); #1;
    ext_push = 0; ext_break = 0; lb_push = 0; pop = 0; irq_clr = 0; stat_clr = 0;
    tog = (fifo_mode != m_mode);
    exp_vld = 0; have_dat = 0; exp_dat = 0;
    if (ic) m_irq = 0;
    if (sc) m_stat = 0;
    if (tog) begin
      m_q.delete();
      m_mode = fifo_mode;
    end else begin
      depth = m_mode ? DEPTH : 1;
      if (po) begin
        exp_vld = 1;
        if (m_q.size() > 0) begin
          exp_dat = m_q.pop_front();
          have_dat = 1;
          m_stat = exp_dat >> 8;
        end
        if (m_q.size() + 1 == TRIG) m_irq = 0;
      end
      sv = 0; se = 0;
      if (loopback) begin sv = lp; se = int'(le); end
      else if (eb)  begin sv = 1; se = 'h400; end
      else if (ep)  begin sv = 1; se = int'({ef, ec}); end
      if (sv && m_q.size() < depth) begin
        m_q.push_back(se);
        if (m_q.size() == TRIG) m_irq = 1;
      end
    end
    chk(tag, "rd_valid", int'(rd_valid), int'(exp_vld));
    if (have_dat) chk(tag, "rd_data", int'(rd_data), exp_dat);
    chk(tag, "level", int'(level), m_q.size());
    chk("R5", "full", int'(full), int'(m_q.size() == (m_mode ? DEPTH : 1)));
    chk("R5", "empty", int'(empty), int'(m_q.size() == 0));
    chk("R8", "rx_irq", int'(rx_irq), int'(m_irq));
    chk("R9", "stat", int'(stat), m_stat);
    chk("R12", "tx_flush", int'(tx_flush), int'(tog));
  endtask

  task automatic put(input bit [7:0] c, input bit [3:0] f, input string t);
    cyc(1, c, f, 0, 0, '0, 0, 0, 0, t);
  endtask
  task automatic take(input string t);
    cyc(0, '0, '0, 0, 0, '0, 1, 0, 0, t);
  endtask
  task automatic idle(input string t);
    cyc(0, '0, '0, 0, 0, '0, 0, 0, 0, t);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "level", int'(level), 0);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "rx_irq", int'(rx_irq), 0);
    chk("R1", "stat", int'(stat), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "tx_flush", int'(tx_flush), 0);
    rst = 0;

    // single-entry mode
    put(8'h41, 4'h1, "R3");
    put(8'h42, 4'h0, "R4");
    take("R3");
    take("R6");

    // switch to queue mode
    fifo_mode = 1'b1;
    idle("R12");
    idle("R12");

    // fill/drain sweep over every level, including overfill and empty pops
    for (int n = 1; n <= DEPTH + 2; n++) begin
      for (int i = 0; i < n; i++) put(8'((n * 37 + i * 11) & 255), 4'(i + n), (i >= DEPTH) ? "R4" : "R2");
      for (int i = 0; i <= n; i++) take((i >= n || i >= DEPTH) ? "R6" : "R2");
    end

    // pop and push together at full and at empty
    for (int i = 0; i < DEPTH; i++) put(8'(i + 100), 4'(i), "R2");
    for (int k = 0; k < 20; k++) cyc(1, 8'(k * 5), 4'(k), 0, 0, '0, 1, 0, 0, "R7");
    for (int i = 0; i <= DEPTH; i++) take("R7");
    cyc(1, 8'h77, 4'h2, 0, 0, '0, 1, 0, 0, "R7");
    take("R7");

    // interrupt set/clear against the trigger
    put(8'h01, 4'h0, "R8"); put(8'h02, 4'h0, "R8"); put(8'h03, 4'h0, "R8");
    cyc(0, '0, '0, 0, 0, '0, 0, 1, 0, "R8");
    put(8'h04, 4'h0, "R8");
    take("R8"); take("R8"); take("R8"); take("R8");
    put(8'h05, 4'h0, "R8");
    cyc(1, 8'h06, 4'h0, 0, 0, '0, 0, 1, 0, "R8");
    take("R8"); take("R8");
    cyc(1, 8'h07, 4'h0, 0, 0, '0, 0, 1, 0, "R8");
    take("R8");

    // status register load and clear
    put(8'h10, 4'hB, "R9"); put(8'h11, 4'h6, "R9");
    cyc(0, '0, '0, 0, 0, '0, 1, 0, 1, "R9");
    cyc(0, '0, '0, 0, 0, '0, 0, 0, 1, "R9");
    take("R9");
    take("R6");

    // line break from outside
    cyc(0, '0, '0, 1, 0, '0, 0, 0, 0, "R10");
    cyc(1, 8'h55, 4'h1, 1, 0, '0, 0, 0, 0, "R10");
    take("R10"); take("R10");

    // loopback routing
    loopback = 1'b1;
    put(8'h66, 4'h0, "R11");
    cyc(0, '0, '0, 1, 0, '0, 0, 0, 0, "R11");
    cyc(0, '0, '0, 0, 1, 12'hA5C, 0, 0, 0, "R11");
    take("R11");
    loopback = 1'b0;
    cyc(0, '0, '0, 0, 1, 12'h321, 0, 0, 0, "R11");

    // mode change flushes
    put(8'h21, 4'h0, "R12"); put(8'h22, 4'h0, "R12"); put(8'h23, 4'h0, "R12");
    fifo_mode = 1'b0;
    cyc(1, 8'h24, 4'h0, 0, 0, '0, 1, 0, 0, "R12");
    idle("R12");
    put(8'h25, 4'h3, "R3");
    fifo_mode = 1'b1;
    idle("R12");

    // long mixed run
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 97 == 0) fifo_mode = ~fifo_mode;
      if ($urandom % 53 == 0) loopback = ~loopback;
      cyc(($urandom % 2) == 0, 8'($urandom), 4'($urandom), ($urandom % 17) == 0,
          ($urandom % 2) == 0, 12'($urandom), ($urandom % 100) < 45,
          ($urandom % 23) == 0, ($urandom % 19) == 0, "R7");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule